// File: doc/BRIEF.md
# Scan Test Vector Sequencer

This block drives a circuit under test through a single multiplexed scan chain. Test vectors come in through a ready/valid port; each carries the state word to load into the chain, a primary-input word, the expected chain response and the expected primary outputs. Each expected word has a care mask beside it. For every vector the block shifts the state in serially. It then gives one normal-mode clock, with the primary inputs applied and the primary outputs observed, to capture the next state. The captured response of that vector is shifted out while the next vector is shifted in.

The block drives a clock enable, a test-control line, the serial scan input and the primary inputs. It samples the serial scan output and the primary outputs. After the vector marked last, one extra shift window unloads the final response. The block then raises a done flag. Any mismatch on a cared-for bit sets a sticky fail flag and records the zero-based index of the first failing vector. If no vector is waiting when a shift window is about to start, the clock enable stays low and the chain holds its contents.

Top module: `scan_vec_seq`

## Requirements
- R1: After reset, cut_ce, cut_tc, done and fail are 0 and in_ready is 1.
- R2: cut_tc=0 with cut_ce=1 is a shift clock and cut_tc=1 with cut_ce=1 is a capture clock. Each capture comes after exactly N_SFF enabled shift clocks and lasts exactly one cycle. cut_tc is never 1 while cut_ce is 0.
- R3: In step k (k=0 first) of a vector's shift window, cut_scan_in carries bit N_SFF-1-k of that vector's state word. A chain that moves bit i to bit i+1 and takes cut_scan_in into bit 0 therefore holds the state word exactly at the capture cycle.
- R4: cut_pi equals the vector's primary-input word during its capture cycle and is 0 during every shift cycle.
- R5: In step k of a shift window, cut_scan_out is compared with bit N_SFF-1-k of the previous vector's expected response. Only bits whose care-mask bit is 1 can flag a mismatch. Nothing is compared during the first window after reset.
- R6: During a capture cycle, cut_po is compared with the vector's expected primary outputs. Only bits whose care-mask bit is 1 can flag a mismatch.
- R7: fail is sticky. fail_idx holds the acceptance-order index, starting at 0, of the first vector with a cared-for mismatch, on the chain response or on the primary outputs. Later mismatches leave it unchanged.
- R8: After the capture of the vector with in_last=1, one more N_SFF-cycle shift window unloads its response. Then done rises and stays 1, and cut_ce stays 0.
- R9: A session of n vectors has exactly (n+1)·N_SFF + n cycles with cut_ce=1.
- R10: If no vector is held when a capture ends, cut_ce and cut_tc stay 0 until one arrives. Shifting then resumes with the chain contents intact.
- R11: A vector is accepted on a cycle with in_valid and in_ready both 1. It is held in a one-entry buffer, which is freed when the vector is loaded for shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Vector offered |
| in_ready | output | 1 | Vector buffer free |
| in_state | input | N_SFF | State word to load into the chain |
| in_pi | input | PI_W | Primary-input word for the capture cycle |
| in_exp_scan | input | N_SFF | Expected captured chain response |
| in_care_scan | input | N_SFF | Care mask for the chain response (1 = compare) |
| in_exp_po | input | PO_W | Expected primary outputs |
| in_care_po | input | PO_W | Care mask for the primary outputs (1 = compare) |
| in_last | input | 1 | Marks the final vector of the session |
| cut_ce | output | 1 | Clock enable for the circuit under test |
| cut_tc | output | 1 | Test control: 0 shift, 1 normal capture |
| cut_scan_in | output | 1 | Serial scan data into the chain |
| cut_pi | output | PI_W | Primary inputs to the circuit |
| cut_scan_out | input | 1 | Serial scan data from the chain end |
| cut_po | input | PO_W | Primary outputs of the circuit |
| done | output | 1 | Session complete |
| fail | output | 1 | Sticky mismatch flag |
| fail_idx | output | IDX_W | Index of the first failing vector |

## Verification
On every cycle, assertions check the shape of the phases. Each capture is a single cycle that follows a full shift window, the step counter advances by one inside a window, test control never rises without the clock enable, the primary inputs stay quiet while shifting, the held vector stays stable, the block stays waiting while no vector is offered, and done and fail with its index stay fixed once set. Only the bench scenarios can show the data results. These are the bit order that leaves the chain holding each state word at capture, the masking of deliberately wrong expected bits, the blaming of the right vector for errors on the chain and on the primary outputs, including the final unload, the exact enabled-cycle total, and that a long stall leaves the chain intact.

// File: rtl/scan_vec_seq_pkg.sv
package scan_vec_seq_pkg;

    typedef enum logic [1:0] {
        PH_WAIT  = 2'd0,
        PH_SHIFT = 2'd1,
        PH_CAPT  = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

    // one observed bit against its expected value; only cared-for bits count
    function automatic logic bit_miss(input logic got, input logic expv, input logic care);
        return care & (got ^ expv);
    endfunction

    function automatic int count_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/svs_vec_hold.sv
module svs_vec_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         full,
    output logic [W-1:0] data,
    input  logic         take
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (!full) begin
            if (in_valid) begin
                full <= 1'b1;
                data <= in_data;
            end
        end else if (take) begin
            full <= 1'b0;
        end
    end

    assign in_ready = !full;

    // R11: a held vector is neither lost nor altered until taken
    assert_hold_stable_R11: assert property (@(posedge clk) disable iff (rst)
        (full && !take) |=> (full && $stable(data)));

endmodule

// File: rtl/svs_ctrl.sv
module svs_ctrl
    import scan_vec_seq_pkg::*;
#(
    parameter int N_SFF = 8,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold_valid,
    input  logic          work_last,
    output phase_e        phase,
    output logic [CW-1:0] step,
    output logic          first_win,
    output logic          unload,
    output logic          load_work,
    output logic          end_capture
);

    localparam logic [CW-1:0] LAST = CW'(N_SFF - 1);

    always_comb begin
        end_capture = (phase == PH_CAPT);
        load_work   = hold_valid &&
                      ((phase == PH_WAIT) || (phase == PH_CAPT && !work_last));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_WAIT;
            step      <= '0;
            first_win <= 1'b1;
            unload    <= 1'b0;
        end else begin
            case (phase)
                PH_WAIT: begin
                    if (hold_valid) begin
                        phase <= PH_SHIFT;
                        step  <= '0;
                    end
                end
                PH_SHIFT: begin
                    if (step == LAST) begin
                        step <= '0;
                        if (unload) begin
                            phase <= PH_DONE;
                        end else begin
                            phase     <= PH_CAPT;
                            first_win <= 1'b0;
                        end
                    end else begin
                        step <= step + CW'(1);
                    end
                end
                PH_CAPT: begin
                    step <= '0;
                    if (work_last) begin
                        phase  <= PH_SHIFT;
                        unload <= 1'b1;
                    end else if (hold_valid) begin
                        phase <= PH_SHIFT;
                    end else begin
                        phase <= PH_WAIT;
                    end
                end
                default: phase <= PH_DONE;
            endcase
        end
    end

    assert_capture_single_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CAPT) |=> (phase != PH_CAPT));

    assert_capture_after_window_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CAPT) |-> ($past(phase) == PH_SHIFT && $past(step) == LAST));

    assert_step_advance_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SHIFT && step != LAST) |=> (phase == PH_SHIFT && step == $past(step) + CW'(1)));

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DONE) |=> (phase == PH_DONE));

    assert_stall_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT && !hold_valid) |=> (phase == PH_WAIT));

endmodule

// File: rtl/svs_resp_cmp.sv
module svs_resp_cmp
    import scan_vec_seq_pkg::*;
#(
    parameter int PO_W  = 4,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scan_en,
    input  logic             scan_got,
    input  logic             scan_exp,
    input  logic             scan_care,
    input  logic [IDX_W-1:0] scan_idx,
    input  logic             po_en,
    input  logic [PO_W-1:0]  po_got,
    input  logic [PO_W-1:0]  po_exp,
    input  logic [PO_W-1:0]  po_care,
    input  logic [IDX_W-1:0] po_idx,
    output logic             fail,
    output logic [IDX_W-1:0] fail_idx
);

    logic [PO_W-1:0]  po_miss_bits;
    logic             scan_miss;
    logic             po_miss;
    logic [IDX_W-1:0] blame_idx;

    for (genvar b = 0; b < PO_W; b++) begin : g_po_bit
        assign po_miss_bits[b] = bit_miss(po_got[b], po_exp[b], po_care[b]);
    end

    always_comb begin
        scan_miss = scan_en && bit_miss(scan_got, scan_exp, scan_care);
        po_miss   = po_en && (|po_miss_bits);
        blame_idx = scan_en ? scan_idx : po_idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fail     <= 1'b0;
            fail_idx <= '0;
        end else if (!fail && (scan_miss || po_miss)) begin
            fail     <= 1'b1;
            fail_idx <= blame_idx;
        end
    end

    assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        fail |=> (fail && $stable(fail_idx)));

    assert_phases_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        !(scan_en && po_en));

endmodule

// File: rtl/scan_vec_seq.sv
module scan_vec_seq
    import scan_vec_seq_pkg::*;
#(
    parameter int N_SFF = 8,
    parameter int PI_W  = 4,
    parameter int PO_W  = 4,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [N_SFF-1:0] in_state,
    input  logic [PI_W-1:0]  in_pi,
    input  logic [N_SFF-1:0] in_exp_scan,
    input  logic [N_SFF-1:0] in_care_scan,
    input  logic [PO_W-1:0]  in_exp_po,
    input  logic [PO_W-1:0]  in_care_po,
    input  logic             in_last,
    output logic             cut_ce,
    output logic             cut_tc,
    output logic             cut_scan_in,
    output logic [PI_W-1:0]  cut_pi,
    input  logic             cut_scan_out,
    input  logic [PO_W-1:0]  cut_po,
    output logic             done,
    output logic             fail,
    output logic [IDX_W-1:0] fail_idx
);

    localparam int CW = count_width(N_SFF);
    localparam logic [CW-1:0] LAST = CW'(N_SFF - 1);

    typedef struct packed {
        logic             last;
        logic [N_SFF-1:0] state;
        logic [PI_W-1:0]  pi;
        logic [N_SFF-1:0] exp_scan;
        logic [N_SFF-1:0] care_scan;
        logic [PO_W-1:0]  exp_po;
        logic [PO_W-1:0]  care_po;
    } vec_t;

    localparam int VW = $bits(vec_t);

    vec_t             in_vec;
    vec_t             hold_vec;
    logic [VW-1:0]    hold_bits;
    logic             hold_full;
    vec_t             work_q;
    logic [IDX_W-1:0] work_idx_q;
    logic [IDX_W-1:0] load_cnt_q;
    logic [N_SFF-1:0] chk_exp_q;
    logic [N_SFF-1:0] chk_care_q;
    logic [IDX_W-1:0] chk_idx_q;

    phase_e           phase;
    logic [CW-1:0]    step;
    logic [CW-1:0]    bit_sel;
    logic             first_win;
    logic             unload;
    logic             load_work;
    logic             end_capture;
    logic             shifting;
    logic             capturing;

    always_comb begin
        in_vec.last      = in_last;
        in_vec.state     = in_state;
        in_vec.pi        = in_pi;
        in_vec.exp_scan  = in_exp_scan;
        in_vec.care_scan = in_care_scan;
        in_vec.exp_po    = in_exp_po;
        in_vec.care_po   = in_care_po;
        hold_vec         = hold_bits;
    end

    svs_vec_hold #(.W(VW)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_vec),
        .full     (hold_full),
        .data     (hold_bits),
        .take     (load_work)
    );

    svs_ctrl #(.N_SFF(N_SFF), .CW(CW)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .hold_valid  (hold_full),
        .work_last   (work_q.last),
        .phase       (phase),
        .step        (step),
        .first_win   (first_win),
        .unload      (unload),
        .load_work   (load_work),
        .end_capture (end_capture)
    );

    // working vector, and the expectation of the response now being unloaded
    always_ff @(posedge clk) begin
        if (rst) begin
            work_q     <= '0;
            work_idx_q <= '0;
            load_cnt_q <= '0;
            chk_exp_q  <= '0;
            chk_care_q <= '0;
            chk_idx_q  <= '0;
        end else begin
            if (end_capture) begin
                chk_exp_q  <= work_q.exp_scan;
                chk_care_q <= work_q.care_scan;
                chk_idx_q  <= work_idx_q;
            end
            if (load_work) begin
                work_q     <= hold_vec;
                work_idx_q <= load_cnt_q;
                load_cnt_q <= load_cnt_q + IDX_W'(1);
            end
        end
    end

    // the bit nearest the chain end goes first
    assign bit_sel   = LAST - step;
    assign shifting  = (phase == PH_SHIFT);
    assign capturing = (phase == PH_CAPT);

    always_comb begin
        cut_ce      = shifting || capturing;
        cut_tc      = capturing;
        cut_scan_in = (shifting && !unload) ? work_q.state[bit_sel] : 1'b0;
        cut_pi      = capturing ? work_q.pi : '0;
        done        = (phase == PH_DONE);
    end

    svs_resp_cmp #(.PO_W(PO_W), .IDX_W(IDX_W)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .scan_en   (shifting && !first_win),
        .scan_got  (cut_scan_out),
        .scan_exp  (chk_exp_q[bit_sel]),
        .scan_care (chk_care_q[bit_sel]),
        .scan_idx  (chk_idx_q),
        .po_en     (capturing),
        .po_got    (cut_po),
        .po_exp    (work_q.exp_po),
        .po_care   (work_q.care_po),
        .po_idx    (work_idx_q),
        .fail      (fail),
        .fail_idx  (fail_idx)
    );

    assert_tc_needs_ce_R2: assert property (@(posedge clk) disable iff (rst)
        cut_tc |-> cut_ce);

    assert_pi_quiet_shift_R4: assert property (@(posedge clk) disable iff (rst)
        (cut_ce && !cut_tc) |-> (cut_pi == '0));

    assert_done_no_clock_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> (done && !cut_ce));

endmodule

// File: tb/scan_vec_seq_bench.sv
module scan_vec_seq_bench;

    localparam int N   = 8;
    localparam int PIW = 4;
    localparam int POW = 4;
    localparam int IW  = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic [N-1:0]   in_state = '0;
    logic [PIW-1:0] in_pi = '0;
    logic [N-1:0]   in_exp_scan = '0;
    logic [N-1:0]   in_care_scan = '0;
    logic [POW-1:0] in_exp_po = '0;
    logic [POW-1:0] in_care_po = '0;
    logic           in_last = 1'b0;
    logic           cut_ce, cut_tc, cut_scan_in, cut_scan_out;
    logic [PIW-1:0] cut_pi;
    logic [POW-1:0] cut_po;
    logic           done, fail;
    logic [IW-1:0]  fail_idx;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    scan_vec_seq u_scan_vec_seq (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_state(in_state), .in_pi(in_pi), .in_exp_scan(in_exp_scan),
        .in_care_scan(in_care_scan), .in_exp_po(in_exp_po), .in_care_po(in_care_po),
        .in_last(in_last), .cut_ce(cut_ce), .cut_tc(cut_tc), .cut_scan_in(cut_scan_in),
        .cut_pi(cut_pi), .cut_scan_out(cut_scan_out), .cut_po(cut_po),
        .done(done), .fail(fail), .fail_idx(fail_idx)
    );

    // circuit-under-test model: chain moves toward bit N-1, scan out from bit N-1
    function automatic logic [N-1:0] cut_next(input logic [N-1:0] s, input logic [PIW-1:0] p);
        return {s[N-2:0], s[N-1]} ^ {p, p};
    endfunction

    function automatic logic [POW-1:0] cut_out(input logic [N-1:0] s, input logic [PIW-1:0] p);
        return s[3:0] ^ s[7:4] ^ p;
    endfunction

    logic [N-1:0] chain_m;
    always @(posedge clk) begin
        if (rst)         chain_m <= 8'h3C;
        else if (cut_ce) chain_m <= cut_tc ? cut_next(chain_m, cut_pi) : {chain_m[N-2:0], cut_scan_in};
    end
    assign cut_scan_out = chain_m[N-1];
    assign cut_po       = cut_out(chain_m, cut_pi);

    task automatic check(input bit ok, input string req, input string what, input int got, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, expv);
        end
    endtask

    // scoreboard: driver pushes what each capture must see
    typedef struct {
        logic [N-1:0]   state;
        logic [PIW-1:0] pi;
    } exp_cap_t;
    exp_cap_t exp_q[$];

    int ce_count = 0;
    int run_len  = 0;
    bit done_seen = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            ce_count  = 0;
            run_len   = 0;
            done_seen = 1'b0;
        end else begin
            if (cut_ce) ce_count++;
            if (cut_ce && !cut_tc) begin
                run_len++;
                check(cut_pi == '0, "R4", "pi during shift", int'(cut_pi), 0);
            end
            if (cut_ce && cut_tc) begin
                check(run_len == N, "R2", "shift clocks before capture", run_len, N);
                run_len = 0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected capture", 1, 0);
                end else begin
                    exp_cap_t e;
                    e = exp_q.pop_front();
                    check(chain_m == e.state, "R3", "chain at capture", int'(chain_m), int'(e.state));
                    check(cut_pi == e.pi, "R4", "pi at capture", int'(cut_pi), int'(e.pi));
                end
            end
            if (done && !done_seen) begin
                done_seen = 1'b1;
                check(run_len == N, "R8", "unload window length", run_len, N);
            end
        end
    end

    task automatic send_vec(input logic [N-1:0] st, input logic [PIW-1:0] p,
                            input logic [N-1:0] es, input logic [N-1:0] cs,
                            input logic [POW-1:0] ep, input logic [POW-1:0] cp, input logic last);
        exp_cap_t e;
        e.state = st;
        e.pi    = p;
        exp_q.push_back(e);
        in_valid = 1'b1; in_state = st; in_pi = p; in_exp_scan = es; in_care_scan = cs;
        in_exp_po = ep; in_care_po = cp; in_last = last;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        exp_q.delete();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // n vectors; bit 5 of one expected chain response and bit 1 of one expected
    // primary-output word can be inverted, with care on or off; optional stall
    task automatic run_session(input int n, input int seed,
                               input int sflip, input bit scare,
                               input int pflip, input bit pcare,
                               input int gap_at, input string tag);
        int exp_idx = -1;
        int wd = 0;
        for (int i = 0; i < n; i++) begin
            logic [N-1:0]   st, es, cs;
            logic [PIW-1:0] p;
            logic [POW-1:0] ep, cp;
            st = N'(i * 37 + seed * 11 + 5);
            p  = PIW'(i * 3 + seed + 1);
            es = cut_next(st, p);
            ep = cut_out(st, p);
            cs = '1;
            cp = '1;
            if (i == sflip) begin
                es[5] = ~es[5];
                if (!scare) cs[5] = 1'b0;
                else if (exp_idx < 0) exp_idx = i;
            end
            if (i == pflip) begin
                ep[1] = ~ep[1];
                if (!pcare) cp[1] = 1'b0;
                else if (exp_idx < 0 || i < exp_idx) exp_idx = i;
            end
            if (i == gap_at) begin
                bit idle = 1'b1;
                repeat (40) @(negedge clk);
                for (int k = 0; k < 5; k++) begin
                    if (cut_ce || cut_tc) idle = 1'b0;
                    @(negedge clk);
                end
                check(idle, "R10", "stall keeps clock enable low", int'(!idle), 0);
                check(in_ready == 1'b1, "R11", "buffer free while stalled", int'(in_ready), 1);
            end
            send_vec(st, p, es, cs, ep, cp, i == n - 1);
        end
        while (!done && wd < 5000) begin
            @(negedge clk);
            wd++;
        end
        check(done == 1'b1, "R8", {tag, " done"}, int'(done), 1);
        repeat (3) @(negedge clk);
        check(!cut_ce && done, "R8", {tag, " idle after done"}, int'(cut_ce), 0);
        check(ce_count == (n + 1) * N + n, "R9", {tag, " enabled cycles"}, ce_count, (n + 1) * N + n);
        check(exp_q.size() == 0, "R2", {tag, " all captures seen"}, exp_q.size(), 0);
        check(fail == (exp_idx >= 0), (sflip >= 0 && scare) ? "R5" : "R6",
              {tag, " fail flag"}, int'(fail), int'(exp_idx >= 0));
        if (exp_idx >= 0)
            check(int'(fail_idx) == exp_idx, "R7", {tag, " first failing index"}, int'(fail_idx), exp_idx);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!cut_ce && !cut_tc, "R1", "no clock after reset", int'(cut_ce), 0);
        check(!done && !fail, "R1", "flags after reset", int'(done) + int'(fail), 0);
        check(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);

        // masked wrong bits on both paths must not fail (R5, R6); stall before vector 3 (R10)
        run_session(5, 1, 2, 1'b0, 3, 1'b0, 3, "masked");
        do_reset();
        // cared chain error on vector 1 wins over later output error (R5, R7)
        run_session(4, 2, 1, 1'b1, 3, 1'b1, -1, "scanfirst");
        do_reset();
        // error in the final unload window blames the last vector (R5, R8)
        run_session(3, 3, 2, 1'b1, -1, 1'b0, -1, "unload");
        do_reset();
        // output error on vector 0 (R6, R7)
        run_session(2, 4, -1, 1'b0, 0, 1'b1, -1, "poerr");
        do_reset();
        // single vector session (R9)
        run_session(1, 5, -1, 1'b0, -1, 1'b0, -1, "single");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired: got 1 expected 0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule